// File: doc/BRIEF.md
# Receive Frame-Sync Detector and Byte Assembler

This block sits behind a demodulator and bit-clock recovery stage. Each recovered bit comes in on a serial input, qualified by a one-cycle valid strobe. The block keeps a window of the 16 most recent bits. On every strobe it compares that window with two fixed frame-sync words, which are bitwise complements of each other. A match sets a sticky flag for that word, and an interrupt line stays high while either flag is set.

The same bit stream is packed into bytes. The first bit of each byte lands in bit 7, and the last complete byte is held on a read-only data output. A sync match resets the byte framing, so payload bytes that follow a sync word come out aligned.

A checksum-checker-busy input blocks detection. Both flags are cleared by a status-read strobe or by dropping the receive enable.

Top module: `rx_sync_deser`

## Requirements
- R1: `sync_det` goes high at the clock edge that samples a strobed bit when the last 16 strobed bits equal 16'hC4D7. The earliest of those bits is bit 15.
- R2: `synt_det` goes high in the same way for the word 16'h3B28. The two flags never rise on the same edge.
- R3: When `chk_active` is high on the strobe that carries the 16th bit, neither flag is set and the byte framing is left unchanged.
- R4: A `stat_rd` pulse clears both flags at the next edge. If a match completes on that same edge, the flag for the matched word is set and the other flag is cleared.
- R5: While `rx_enable` is low, both flags, the 16-bit history and the byte bit count are cleared. After enabling, a match needs 16 strobed bits received since the enable.
- R6: `irq` is high exactly when `sync_det` or `synt_det` is high.
- R7: Every 8th strobed bit since the last framing point loads `rx_data`. The first bit of that group goes to bit 7 and the last to bit 0.
- R8: After a detected match, the next strobed bit becomes bit 7 of a new byte.
- R9: After reset, `rx_data` is 0 and `sync_det`, `synt_det` and `irq` are low.
- R10: `bit_in` is ignored while `bit_valid` is low. `rx_data` and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_enable | input | 1 | Receive enable; low clears detection state |
| bit_in | input | 1 | Recovered serial bit |
| bit_valid | input | 1 | One-cycle strobe qualifying `bit_in` |
| chk_active | input | 1 | High while the checksum checker runs; blocks detection |
| stat_rd | input | 1 | Status read strobe; clears both flags |
| rx_data | output | 8 | Last complete received byte, first bit at bit 7 |
| sync_det | output | 1 | Sticky flag for word 16'hC4D7 |
| synt_det | output | 1 | Sticky flag for word 16'h3B28 |
| irq | output | 1 | Interrupt, high while either flag is set |

## Verification
Plain bytes with no sync word check only the MSB-first packing. A sync word placed three bits off a byte boundary, followed by a payload byte, shows whether the framing realigns. Each of the two words is sent alone, which separates the two comparators: since the words are complements, swapped or inverted comparators show up here. Further runs cover the word with the checksum checker busy, a read on the same edge as a match, and a partial word right after re-enabling. The last of these would match falsely if the cleared history counted as received bits.

// File: rtl/rxsd_pkg.sv
package rxsd_pkg;
    parameter int HIST_W = 16;
    parameter int BYTE_W = 8;
    parameter int NUM_PAT = 2;
    parameter logic [HIST_W-1:0] SYNC_WORD = 16'hC4D7;
    parameter logic [HIST_W-1:0] SYNT_WORD = ~SYNC_WORD;
endpackage

// File: rtl/rxsd_history.sv
module rxsd_history #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         valid,
    input  logic         bit_in,
    output logic [W-1:0] hist_nx,
    output logic         full_nx
);
    localparam int FW = $clog2(W + 1);
    localparam logic [FW-1:0] FULL = FW'(W);

    typedef struct packed {
        logic [W-1:0]  hist;
        logic [FW-1:0] fill;
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (valid) begin
            st_d.hist = {st_q.hist[W-2:0], bit_in};
            if (st_q.fill != FULL) st_d.fill = st_q.fill + 1'b1;
        end
        hist_nx = st_d.hist;
        full_nx = (st_d.fill == FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rxsd_match.sv
module rxsd_match #(
    parameter int W = 16,
    parameter logic [W-1:0] PAT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         strobe,
    input  logic         gate,
    input  logic         rd,
    input  logic [W-1:0] hist_nx,
    input  logic         full_nx,
    output logic         hit,
    output logic         flag
);
    logic flag_d, flag_q;

    always_comb begin
        hit    = en && strobe && !gate && full_nx && (hist_nx == PAT);
        flag_d = flag_q;
        if (!en)       flag_d = 1'b0;
        else if (hit)  flag_d = 1'b1;
        else if (rd)   flag_d = 1'b0;
        flag = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    AST_SET_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(strobe)); // R1
    AST_GATED_BY_CHK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> !$past(gate)); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !strobe) |=> !flag_q); // R4
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !flag_q); // R5
    AST_FRESH_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(full_nx)); // R5
endmodule

// File: rtl/rxsd_bytes.sv
module rxsd_bytes #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          valid,
    input  logic          bit_in,
    input  logic          realign,
    output logic [BW-1:0] data
);
    localparam int CW = $clog2(BW);
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    typedef struct packed {
        logic [BW-1:0] sh;
        logic [CW-1:0] cnt;
        logic [BW-1:0] data;
    } byte_st_t;

    byte_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else if (valid) begin
            st_d.sh = {st_q.sh[BW-2:0], bit_in};
            if (st_q.cnt == LAST) begin
                st_d.data = st_d.sh;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (realign) st_d.cnt = '0;
        end
        data = st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(st_q.data)); // R10
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0)); // R5
endmodule

// File: rtl/rx_sync_deser.sv
module rx_sync_deser
    import rxsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_enable,
    input  logic       bit_in,
    input  logic       bit_valid,
    input  logic       chk_active,
    input  logic       stat_rd,
    output logic [7:0] rx_data,
    output logic       sync_det,
    output logic       synt_det,
    output logic       irq
);
    localparam logic [NUM_PAT-1:0][HIST_W-1:0] PATS = {SYNT_WORD, SYNC_WORD};

    logic [HIST_W-1:0]  hist_nx;
    logic               full_nx;
    logic [NUM_PAT-1:0] hits;
    logic [NUM_PAT-1:0] flags;

    rxsd_history #(.W(HIST_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_enable),
        .valid   (bit_valid),
        .bit_in  (bit_in),
        .hist_nx (hist_nx),
        .full_nx (full_nx)
    );

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        rxsd_match #(.W(HIST_W), .PAT(PATS[g])) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (rx_enable),
            .strobe  (bit_valid),
            .gate    (chk_active),
            .rd      (stat_rd),
            .hist_nx (hist_nx),
            .full_nx (full_nx),
            .hit     (hits[g]),
            .flag    (flags[g])
        );
    end

    rxsd_bytes #(.BW(BYTE_W)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_enable),
        .valid   (bit_valid),
        .bit_in  (bit_in),
        .realign (|hits),
        .data    (rx_data)
    );

    always_comb begin
        sync_det = flags[0];
        synt_det = flags[1];
        irq      = |flags;
    end

    AST_WORDS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(sync_det) && $rose(synt_det))); // R2
    AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !stat_rd && rx_enable) |=> ($stable(sync_det) && $stable(synt_det))); // R10
endmodule

// File: tb/rx_sync_deser_test.sv
module rx_sync_deser_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic       chk_active = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rx_data;
    logic       sync_det, synt_det, irq;

    int checks = 0;
    int errors = 0;

    rx_sync_deser uut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .bit_in(bit_in),
        .bit_valid(bit_valid), .chk_active(chk_active), .stat_rd(stat_rd),
        .rx_data(rx_data), .sync_det(sync_det), .synt_det(synt_det), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [7:0] d;
        logic       s;
        logic       t;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state derived from the requirements
    logic [15:0] m_hist = '0;
    int          m_fill = 0;
    int          m_cnt = 0;
    logic [7:0]  m_sh = '0;
    logic [7:0]  m_data = '0;
    logic        m_sync = 1'b0;
    logic        m_synt = 1'b0;

    task automatic step(input logic en, input logic v, input logic b,
                        input logic chk, input logic rd, input string tag);
        exp_t e;
        logic hs, ht;
        @(negedge clk);
        rx_enable = en; bit_valid = v; bit_in = b; chk_active = chk; stat_rd = rd;
        if (!en) begin
            m_hist = '0; m_fill = 0; m_cnt = 0; m_sync = 0; m_synt = 0;
        end else begin
            if (rd) begin m_sync = 0; m_synt = 0; end
            if (v) begin
                m_hist = {m_hist[14:0], b};
                if (m_fill < 16) m_fill++;
                m_sh = {m_sh[6:0], b};
                if (m_cnt == 7) begin m_data = m_sh; m_cnt = 0; end
                else m_cnt++;
                hs = !chk && m_fill == 16 && m_hist == 16'hC4D7;
                ht = !chk && m_fill == 16 && m_hist == 16'h3B28;
                if (hs) m_sync = 1;
                if (ht) m_synt = 1;
                if (hs || ht) m_cnt = 0;
            end
        end
        e.d = m_data; e.s = m_sync; e.t = m_synt; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send_word(input logic [15:0] w, input int n, input logic chk,
                             input logic rd_last, input string tag);
        for (int i = n - 1; i >= 0; i--)
            step(1'b1, 1'b1, w[i], chk, (i == 0) ? rd_last : 1'b0, tag);
    endtask

    // Monitor: compares each scoreboard entry after the edge it belongs to
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (rx_data !== e.d || sync_det !== e.s || synt_det !== e.t ||
                    irq !== (e.s | e.t)) begin
                    errors++;
                    $display("FAIL %s: data=%h sync=%b synt=%b irq=%b exp data=%h sync=%b synt=%b irq=%b",
                             e.tag, rx_data, sync_det, synt_det, irq, e.d, e.s, e.t, e.s | e.t);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, exp done expected");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        checks++;   // R9 reset state
        if (rx_data !== 8'h00 || sync_det || synt_det || irq) begin
            errors++;
            $display("FAIL R9: data=%h sync=%b synt=%b irq=%b exp 00 0 0 0",
                     rx_data, sync_det, synt_det, irq);
        end
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle after reset");

        // R7: plain bytes, MSB first
        send_word(16'hA53C, 16, 1'b0, 1'b0, "R7 byte packing");
        // R10: bit_in toggles without strobe
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, i[0], 1'b0, 1'b0, "R10 ignored bits");

        // R1 + R8: sync word three bits off a boundary, then payload
        send_word(16'h0005, 3, 1'b0, 1'b0, "R8 misalign");
        send_word(16'hC4D7, 16, 1'b0, 1'b0, "R1 sync word");
        send_word(16'h005A, 8, 1'b0, 1'b0, "R8 realigned byte");
        // R6 irq held, R10 flags hold
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 irq while flag set");
        // R4: read clears
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 read clear");

        // R2: synt word
        send_word(16'h3B28, 16, 1'b0, 1'b0, "R2 synt word");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 read clear synt");

        // R4: read on the same edge as a match, with the other flag set
        send_word(16'h3B28, 16, 1'b0, 1'b0, "R2 synt again");
        send_word(16'hC4D7, 16, 1'b0, 1'b1, "R4 read with match");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 clear");

        // R3: checksum busy blocks detection and realignment
        send_word(16'h0001, 1, 1'b0, 1'b0, "R3 offset");
        send_word(16'hC4D7, 16, 1'b1, 1'b0, "R3 chk busy");
        send_word(16'hF00F, 16, 1'b0, 1'b0, "R3 framing kept");

        // R5: disable clears, cleared history does not count
        send_word(16'h3B28, 16, 1'b0, 1'b0, "R5 set before disable");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 disable");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 re-enable");
        send_word(16'h3B28, 14, 1'b0, 1'b0, "R5 partial word");
        send_word(16'h3B28, 16, 1'b0, 1'b0, "R5 full word");
        send_word(16'h00C3, 8, 1'b0, 1'b0, "R8 after synt");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 final");

        @(negedge clk); @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule